// File: doc/BRIEF.md
# Parallel Two-Tone Digital Sine Synthesizer

This block synthesizes the sum of two digital sinusoids. Every core clock it delivers sixteen consecutive samples side by side, so the effective sample rate is sixteen times the core clock. Each tone has its own 10-bit frequency word and its own attenuation index. The phase register has the same width as the sine table address, so every phase bit reaches the lookup and no phase is truncated.

Sixteen lane phases are formed from one shared accumulator per tone. Each lane phase addresses a full 1024-entry sine table. The looked-up sample is scaled by a gain made only of shifted and added copies, then halved, and the two tones are added lane by lane. The pipeline has four register stages. A valid flag marks the output once the pipeline has filled after reset.

Top module: `tone_pair_dds`

## Requirements
- R1: The output carries 16 lanes of 16-bit two's-complement samples. Lane k occupies bits [16k+15:16k], and lane 0 is the earliest sample of the clock.
- R2: For each tone with frequency word F and accumulator P, lane k reads phase (P + k·F) mod 1024. The table entry at phase p is round(32767·sin(2πp/1024)), with halves rounded away from zero.
- R3: Reset clears both accumulators to 0. After every active clock edge the accumulator of a tone grows by 16·F mod 1024.
- R4: A new frequency word is used from the next clock edge and continues from the current accumulator value. The phase is not reset.
- R5: Inputs sampled at a rising edge reach the output after the fourth rising edge, counting the sampling edge as the first.
- R6: With attenuation index 0, a tone contributes exactly floor(s/2), where s is its table value. With both indices 0, each lane equals floor(sa/2) + floor(sb/2).
- R7: An index i from 1 to 96 applies a gain within 0.5 dB of 10^(-i/20). The gain is built from at most three signed power-of-two terms and uses no multiplier. The tone then contributes floor(g·s/2).
- R8: An index above 96 acts exactly like index 96.
- R9: The output never wraps. Two full-scale tones at their common peak give 32766, and at their common trough give -32768.
- R10: While reset is asserted, vld_o and all lanes are 0. After reset release, vld_o rises after the fourth rising edge and stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcw_a_i | input | 10 | Frequency word of tone A |
| fcw_b_i | input | 10 | Frequency word of tone B |
| bo_a_i | input | 7 | Attenuation index of tone A, about 1 dB per step |
| bo_b_i | input | 7 | Attenuation index of tone B, about 1 dB per step |
| smp_o | output | 256 | Sixteen summed samples, lane 0 in the low bits |
| vld_o | output | 1 | Output samples are valid |

## Verification
Two events can fall in the same cycle: a frequency word change, and the wrap of the lane phases from one clock to the next. When both happen together, lane 0 of the next clock must continue from lane 15 plus the old step, and only then take the new step. The bench changes frequency words at random cycles and in directed steps, with indices both zero and non-zero. A bench model applies the same phase rules and the four-cycle delay, and every lane is compared with it. With index zero the comparison is exact. Otherwise the lane must lie inside the 0.5 dB band around the ideal value.

// File: rtl/tpdds_pkg.sv
package tpdds_pkg;
  localparam int DEF_PH_W  = 10;
  localparam int DEF_LANES = 16;
  localparam int DEF_SMP_W = 16;
  localparam int DEF_BO_W  = 7;
  localparam int DEF_BO_MX = 96;
  localparam int DEF_FRAC  = 24;
  localparam int TERMS     = 3;
  localparam int SH_W      = 5;

  typedef struct packed {
    logic            en;
    logic            neg;
    logic [SH_W-1:0] sh;
  } term_t;

  typedef term_t [TERMS-1:0] gain_t;

  function automatic int sine_code(int p, int depth, int amp);
    real v;
    v = amp * $sin(2.0 * 3.141592653589793 * p / depth);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else return -$rtoi(0.5 - v);
  endfunction

  // greedy nearest power-of-two decomposition of 10^(-idx/20) in 2^-frac units
  function automatic gain_t gain_code(int idx, int frac);
    int r, mag, k;
    gain_t g;
    term_t t;
    r = $rtoi($pow(10.0, -idx / 20.0) * $pow(2.0, frac) + 0.5);
    g = '0;
    for (int n = 0; n < TERMS; n++) begin
      mag = (r < 0) ? -r : r;
      t   = '0;
      if (mag > 0) begin
        k = 0;
        for (int b = 0; b < 31; b++) if (mag >= (1 << b)) k = b;
        if (2 * mag > 3 * (1 << k)) k++;
        t.en  = 1'b1;
        t.neg = (r < 0);
        t.sh  = SH_W'(k);
        r     = (r < 0) ? r + (1 << k) : r - (1 << k);
      end
      g[n] = t;
    end
    return g;
  endfunction

  function automatic int magn(int v);
    return (v < 0) ? -v : v;
  endfunction
endpackage

// File: rtl/tpdds_phase.sv
module tpdds_phase
  import tpdds_pkg::*;
#(
  parameter int PH_W  = DEF_PH_W,
  parameter int LANES = DEF_LANES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PH_W-1:0]             fcw_i,
  output logic [LANES-1:0][PH_W-1:0]  ph_o
);
  localparam logic [PH_W-1:0] STEP = PH_W'(LANES);

  logic [PH_W-1:0]            acc_q, fcw_q;
  logic [LANES-1:0][PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      fcw_q <= '0;
      ph_q  <= '0;
    end else begin
      acc_q <= acc_q + PH_W'(STEP * fcw_i);
      fcw_q <= fcw_i;
      for (int l = 0; l < LANES; l++) ph_q[l] <= acc_q + PH_W'(PH_W'(l) * fcw_i);
    end
  end

  assign ph_o = ph_q;

  for (genvar l = 1; l < LANES; l++) begin : g_sp
    p_lane_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      PH_W'(ph_q[l] - ph_q[l-1]) == fcw_q);
  end

  // lane 0 of the next clock continues from the last lane with the old step (R3, R4)
  p_phase_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ph_q[0] == PH_W'($past(ph_q[LANES-1]) + $past(fcw_q)));
endmodule

// File: rtl/tpdds_sine_lut.sv
module tpdds_sine_lut
  import tpdds_pkg::*;
#(
  parameter int PH_W  = DEF_PH_W,
  parameter int LANES = DEF_LANES,
  parameter int SMP_W = DEF_SMP_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0][PH_W-1:0]  ph_i,
  output logic [LANES-1:0][SMP_W-1:0] smp_o
);
  localparam int DEPTH = 1 << PH_W;
  localparam int AMP   = (1 << (SMP_W - 1)) - 1;

  logic [SMP_W-1:0]            tbl [DEPTH];
  logic [LANES-1:0][SMP_W-1:0] smp_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    localparam logic [SMP_W-1:0] VAL = SMP_W'(sine_code(i, DEPTH, AMP));
    assign tbl[i] = VAL;
  end

  // full-width address: selection resolves to a mux tree over all entries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else for (int l = 0; l < LANES; l++) smp_q[l] <= tbl[ph_i[l]];
  end

  assign smp_o = smp_q;
endmodule

// File: rtl/tpdds_gain.sv
module tpdds_gain
  import tpdds_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int SMP_W = DEF_SMP_W,
  parameter int BO_W  = DEF_BO_W,
  parameter int BO_MX = DEF_BO_MX,
  parameter int FRAC  = DEF_FRAC
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [BO_W-1:0]             bo_i,
  input  logic [LANES-1:0][SMP_W-1:0] smp_i,
  output logic [LANES-1:0][SMP_W-1:0] tone_o
);
  localparam int PW = SMP_W + FRAC + 2;

  gain_t                       lut [BO_MX+1];
  gain_t                       g;
  logic [BO_W-1:0]             bo_c, bo_d1, bo_d2;
  logic [LANES-1:0][SMP_W-1:0] tone_d, tone_q;

  for (genvar i = 0; i <= BO_MX; i++) begin : g_lut
    localparam gain_t GV = gain_code(i, FRAC);
    assign lut[i] = GV;
  end

  assign bo_c = (bo_i > BO_W'(BO_MX)) ? BO_W'(BO_MX) : bo_i;
  assign g    = lut[bo_d2];

  always_comb begin
    logic signed [PW-1:0] x, t, s;
    for (int l = 0; l < LANES; l++) begin
      x = PW'($signed(smp_i[l]));
      s = '0;
      for (int n = 0; n < TERMS; n++) begin
        t = x <<< g[n].sh;
        if (g[n].en) s = g[n].neg ? s - t : s + t;
      end
      tone_d[l] = SMP_W'(s >>> (FRAC + 1));
    end
  end

  // index delayed twice to meet its samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bo_d1  <= '0;
      bo_d2  <= '0;
      tone_q <= '0;
    end else begin
      bo_d1  <= bo_c;
      bo_d2  <= bo_d1;
      tone_q <= tone_d;
    end
  end

  assign tone_o = tone_q;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    p_unity_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(bo_d2) == '0 |-> $signed(tone_q[l]) == ($signed($past(smp_i[l])) >>> 1));
    p_no_gain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      magn(int'($signed(tone_q[l]))) <= (magn(int'($signed($past(smp_i[l])))) >> 1) + 1);
  end
endmodule

// File: rtl/tone_pair_dds.sv
module tone_pair_dds
  import tpdds_pkg::*;
#(
  parameter int PH_W  = DEF_PH_W,
  parameter int LANES = DEF_LANES,
  parameter int SMP_W = DEF_SMP_W,
  parameter int BO_W  = DEF_BO_W,
  parameter int BO_MX = DEF_BO_MX,
  parameter int FRAC  = DEF_FRAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PH_W-1:0]          fcw_a_i,
  input  logic [PH_W-1:0]          fcw_b_i,
  input  logic [BO_W-1:0]          bo_a_i,
  input  logic [BO_W-1:0]          bo_b_i,
  output logic [LANES*SMP_W-1:0]   smp_o,
  output logic                     vld_o
);
  localparam int NT    = 2;
  localparam int DEPTH = 4;
  localparam int HALF  = 1 << (SMP_W - 2);

  logic [NT-1:0][PH_W-1:0]     fcw;
  logic [NT-1:0][BO_W-1:0]     bo;
  logic [LANES-1:0][PH_W-1:0]  ph   [NT];
  logic [LANES-1:0][SMP_W-1:0] smp  [NT];
  logic [LANES-1:0][SMP_W-1:0] tone [NT];
  logic [LANES-1:0][SMP_W-1:0] out_q;
  logic [DEPTH-1:0]            vld_sr;

  assign fcw = {fcw_b_i, fcw_a_i};
  assign bo  = {bo_b_i, bo_a_i};

  for (genvar t = 0; t < NT; t++) begin : g_tone
    tpdds_phase #(.PH_W(PH_W), .LANES(LANES)) i_phase (
      .clk_i, .rst_ni, .fcw_i(fcw[t]), .ph_o(ph[t])
    );
    tpdds_sine_lut #(.PH_W(PH_W), .LANES(LANES), .SMP_W(SMP_W)) i_lut (
      .clk_i, .rst_ni, .ph_i(ph[t]), .smp_o(smp[t])
    );
    tpdds_gain #(.LANES(LANES), .SMP_W(SMP_W), .BO_W(BO_W), .BO_MX(BO_MX),
                 .FRAC(FRAC)) i_gain (
      .clk_i, .rst_ni, .bo_i(bo[t]), .smp_i(smp[t]), .tone_o(tone[t])
    );
    for (genvar l = 0; l < LANES; l++) begin : g_rng
      p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $signed(tone[t][l]) >= -HALF && $signed(tone[t][l]) <= HALF - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      vld_sr <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) out_q[l] <= tone[0][l] + tone[1][l];
      vld_sr <= {vld_sr[DEPTH-2:0], 1'b1};
    end
  end

  assign smp_o = out_q;
  assign vld_o = vld_sr[DEPTH-1];

  p_vld_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> vld_o);
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> smp_o == '0);
endmodule

// File: tb/test_tone_pair_dds.sv
module test_tone_pair_dds;
  localparam int L = 16;

  logic         clk = 1'b0, rst_ni = 1'b1;
  logic [9:0]   fcw_a = '0, fcw_b = '0;
  logic [6:0]   bo_a = '0, bo_b = '0;
  logic [255:0] smp;
  logic         vld;

  always #10 clk = ~clk;

  tone_pair_dds i_tone_pair_dds (
    .clk_i(clk), .rst_ni(rst_ni), .fcw_a_i(fcw_a), .fcw_b_i(fcw_b),
    .bo_a_i(bo_a), .bo_b_i(bo_b), .smp_o(smp), .vld_o(vld)
  );

  int    n_run = 0, n_fail = 0, acc_a = 0, acc_b = 0;
  bit    hv [4];
  int    hsa [4][L];
  int    hsb [4][L];
  int    hba [4];
  int    hbb [4];
  string htag [4];
  int    nfa = 0, nfb = 0, nba = 0, nbb = 0;
  bit    nrst = 1'b0;
  string ntag = "R10";

  function automatic int sine_m(int p);
    real v;
    v = 32767.0 * $sin(2.0 * 3.141592653589793 * p / 1024.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic real db_gain(int i);
    return $pow(10.0, -i / 20.0);
  endfunction

  function automatic int clamp96(int i);
    return (i > 96) ? 96 : i;
  endfunction

  function automatic real rabs(real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst_ni) begin
      check(vld == 1'b0, "R10 valid low in reset", int'(vld), 0);
      check(smp == '0, "R10 lanes zero in reset", int'(smp[15:0]), 0);
    end else begin
      check(vld == hv[3], "R10 valid timing", int'(vld), int'(hv[3]));
      if (hv[3]) begin
        for (int l = 0; l < L; l++) begin
          int act;
          act = int'($signed(smp[l*16 +: 16]));
          if (hba[3] == 0 && hbb[3] == 0) begin
            int exp;
            exp = (hsa[3][l] >>> 1) + (hsb[3][l] >>> 1);
            check(act == exp, $sformatf("%s lane %0d R6", htag[3], l), act, exp);
          end else begin
            real ga, gb, ideal, tol;
            ga    = db_gain(hba[3]);
            gb    = db_gain(hbb[3]);
            ideal = 0.5 * (ga * hsa[3][l] + gb * hsb[3][l]);
            tol   = 0.0593 * 0.5 * (ga * rabs(hsa[3][l]) + gb * rabs(hsb[3][l])) + 2.5;
            check(rabs(act - ideal) <= tol, $sformatf("%s lane %0d R7 band", htag[3], l),
                  act, $rtoi(ideal));
          end
        end
      end
    end
    for (int i = 3; i > 0; i--) begin
      hv[i] = hv[i-1]; hsa[i] = hsa[i-1]; hsb[i] = hsb[i-1];
      hba[i] = hba[i-1]; hbb[i] = hbb[i-1]; htag[i] = htag[i-1];
    end
    if (!nrst) begin
      rst_ni = 1'b0;
      acc_a = 0; acc_b = 0;
      for (int i = 0; i < 4; i++) hv[i] = 1'b0;
    end else begin
      rst_ni = 1'b1;
      fcw_a = 10'(nfa); fcw_b = 10'(nfb); bo_a = 7'(nba); bo_b = 7'(nbb);
      hv[0] = 1'b1; hba[0] = clamp96(nba); hbb[0] = clamp96(nbb); htag[0] = ntag;
      for (int l = 0; l < L; l++) begin
        hsa[0][l] = sine_m((acc_a + l * nfa) % 1024);
        hsb[0][l] = sine_m((acc_b + l * nfb) % 1024);
      end
      acc_a = (acc_a + 16 * nfa) % 1024;
      acc_b = (acc_b + 16 * nfb) % 1024;
    end
  endtask

  task automatic run(int fa, int fb, int ba, int bb, string tag, int n);
    nrst = 1'b1; nfa = fa; nfb = fb; nba = ba; nbb = bb; ntag = tag;
    repeat (n) step();
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1 rst_ni = 1'b0;
    nrst = 1'b0; ntag = "R10";
    repeat (3) step();
    run(1, 5, 0, 0, "R1 R2", 40);
    run(0, 0, 0, 0, "R5", 6);
    run(37, 0, 0, 0, "R5", 10);
    run(100, 3, 0, 0, "R4", 20);
    run(613, 900, 0, 0, "R4", 20);
    nrst = 1'b0; ntag = "R3";
    repeat (2) step();
    run(11, 22, 0, 0, "R3", 20);
    nrst = 1'b0;
    repeat (2) step();
    run(256, 256, 0, 0, "R9", 10);
    run(50, 70, 120, 127, "R8", 10);
    run(50, 70, 0, 100, "R8", 10);
    for (int i = 1; i <= 96; i++) run(17 + i, 301, i, 96 - i, "R7", 2);
    for (int c = 0; c < 1500; c++) begin
      if ($urandom_range(0, 7) == 0) nfa = $urandom_range(0, 1023);
      if ($urandom_range(0, 7) == 0) nfb = $urandom_range(0, 1023);
      if ($urandom_range(0, 15) == 0) nba = $urandom_range(0, 1) ? 0 : $urandom_range(0, 127);
      if ($urandom_range(0, 15) == 0) nbb = $urandom_range(0, 1) ? 0 : $urandom_range(0, 127);
      ntag = (nba == 0 && nbb == 0) ? "R2 R4" : "R7";
      nrst = 1'b1;
      step();
    end
    run(0, 0, 0, 0, "R5", 6);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule